// File: doc/BRIEF.md
# Shelving Buffer with Result-Tag Wake-Up

This block holds decoded instructions between dispatch and execution when operands are fetched at dispatch time. Each slot keeps an opcode, the renamed destination tag, and two source fields. Each source field carries either a ready operand value or, while the value is still being computed, the rename tag of the producing instruction. A valid bit per field tells which of the two it holds.

Whenever the execution pipeline finishes, it drives its result together with the result's renamed destination tag. Every waiting source field in every occupied slot compares its tag with that broadcast tag. A field that matches takes the value and becomes valid. A slot being dispatched in the same cycle is compared as well.

Slots leave strictly in arrival order. The oldest slot is sent to the execution unit once both of its fields are valid and the unit reports that it is free. A full buffer refuses dispatch, and a flush input discards every slot.

Top module: `rs_shelf`

## Requirements
- R1: After reset the buffer is empty: `dispReady` is 1 and `issueValid` is 0.
- R2: An issued slot presents the opcode, the destination tag and both operand values exactly as dispatched (or as captured from a broadcast).
- R3: A source field with its valid input at 1 carries an operand value. With it at 0, the field's low `TAG_W` bits carry the rename tag it waits on.
- R4: A broadcast (`bcastValid`=1) whose `bcastTag` equals the tag of a waiting source field writes `bcastData` into that field and sets its valid bit. This applies to every matching field in every occupied slot in the same cycle.
- R5: A broadcast leaves alone every field that is already valid, and every field waiting on a different tag. The comparison key is the renamed tag only.
- R6: Only the oldest slot can issue. A younger slot whose operands are ready waits while an older slot is not ready.
- R7: `issueValid` is 1 only when the oldest slot has both fields valid and `euFree` is 1. An asserted `issueValid` means the slot leaves the buffer at that clock edge.
- R8: A broadcast in the same cycle as a dispatch also fills the matching waiting fields of the slot being dispatched.
- R9: With all `DEPTH` slots occupied, `dispReady` is 0 and a dispatch attempt is ignored: no extra slot is ever issued from it.
- R10: `flush`=1 empties every slot at the next edge. A dispatch in the same cycle is dropped, and `issueValid` is 0 while `flush` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all slots |
| dispValid | input | 1 | Dispatch request |
| dispReady | output | 1 | Buffer can accept a slot |
| dispOp | input | OP_W | Opcode of dispatched instruction |
| dispDest | input | TAG_W | Renamed destination tag |
| srcAValid | input | 1 | Source A holds a value (1) or a tag (0) |
| srcAData | input | DATA_W | Source A value, or tag in low TAG_W bits |
| srcBValid | input | 1 | Source B holds a value (1) or a tag (0) |
| srcBData | input | DATA_W | Source B value, or tag in low TAG_W bits |
| bcastValid | input | 1 | Result broadcast this cycle |
| bcastTag | input | TAG_W | Renamed tag of the broadcast result |
| bcastData | input | DATA_W | Broadcast result value |
| euFree | input | 1 | Execution unit can take an instruction |
| issueValid | output | 1 | Oldest slot is leaving this cycle |
| issueOp | output | OP_W | Opcode of issued slot |
| issueDest | output | TAG_W | Destination tag of issued slot |
| issueOpA | output | DATA_W | Operand A value of issued slot |
| issueOpB | output | DATA_W | Operand B value of issued slot |

## Verification
The bench targets several corner cases. One is a broadcast that wakes two slots at once. A design that matched only the first slot would leave the younger one stalled forever. A second is a broadcast that shares its tag with a field that is already valid. A design that skipped the valid-bit check would corrupt a ready operand. A third is a ready younger slot behind a blocked older one; an out-of-order design would issue it early and show up as a scoreboard mismatch. The bench also covers a broadcast landing on the very cycle of dispatch, which a careless design would lose, leaving the slot waiting. Finally, it drives dispatch into a full buffer and dispatch during a flush. A design that accepted either would later issue an instruction the scoreboard never expected.

// File: rtl/rs_shelf_pkg.sv
package rs_shelf_pkg;

  // Widest slot index the strobe struct can carry (DEPTH up to 32).
  parameter int unsigned IDX_MAX_W = 5;

  typedef struct packed {
    logic                 write;
    logic [IDX_MAX_W-1:0] writeIdx;
    logic                 pop;
    logic [IDX_MAX_W-1:0] popIdx;
    logic                 clear;
  } rsStrobe_t;

endpackage

// File: rtl/rs_shelf_ctrl.sv
module rs_shelf_ctrl
  import rs_shelf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       dispValid,
  input  logic                       euFree,
  input  logic                       headReady,
  output logic                       dispReady,
  output logic                       issueValid,
  output logic [$clog2(DEPTH)-1:0]   headIdx,
  output rsStrobe_t                  strobe
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ;
  logic             full, empty, doWrite, doPop;

  assign full       = (countQ == CNT_W'(DEPTH));
  assign empty      = (countQ == '0);
  assign dispReady  = !full;
  assign doWrite    = dispValid && !full && !flush;
  assign doPop      = !empty && headReady && euFree && !flush;
  assign issueValid = doPop;
  assign headIdx    = headQ;

  assign strobe.write    = doWrite;
  assign strobe.writeIdx = IDX_MAX_W'(tailQ);
  assign strobe.pop      = doPop;
  assign strobe.popIdx   = IDX_MAX_W'(headQ);
  assign strobe.clear    = flush;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else if (flush) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (doWrite) tailQ <= nextPtr(tailQ);
      if (doPop)   headQ <= nextPtr(headQ);
      case ({doWrite, doPop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  // R9: occupancy never exceeds the number of slots.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));

  // R9: a full buffer that does not issue stays full and takes nothing.
  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (full && !doPop && !flush) |=> full && $stable(tailQ));

  // R10: flush leaves the buffer empty.
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (countQ == '0) && dispReady && !headReady);

endmodule

// File: rtl/rs_shelf_data.sv
module rs_shelf_data
  import rs_shelf_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rsStrobe_t                 strobe,
  input  logic [OP_W-1:0]           dispOp,
  input  logic [TAG_W-1:0]          dispDest,
  input  logic                      srcAValid,
  input  logic [DATA_W-1:0]         srcAData,
  input  logic                      srcBValid,
  input  logic [DATA_W-1:0]         srcBData,
  input  logic                      bcastValid,
  input  logic [TAG_W-1:0]          bcastTag,
  input  logic [DATA_W-1:0]         bcastData,
  input  logic [$clog2(DEPTH)-1:0]  headIdx,
  output logic                      headReady,
  output logic [OP_W-1:0]           issueOp,
  output logic [TAG_W-1:0]          issueDest,
  output logic [DATA_W-1:0]         issueOpA,
  output logic [DATA_W-1:0]         issueOpB
);

  logic [OP_W-1:0]   opQ   [DEPTH];
  logic [TAG_W-1:0]  destQ [DEPTH];
  logic [DATA_W-1:0] aQ    [DEPTH];
  logic [DATA_W-1:0] bQ    [DEPTH];
  logic [DEPTH-1:0]  occQ, aVQ, bVQ;

  function automatic logic tagHit(input logic vld, input logic [DATA_W-1:0] fld);
    return !vld && bcastValid && (fld[TAG_W-1:0] == bcastTag);
  endfunction

  logic inAHit, inBHit;
  assign inAHit = tagHit(srcAValid, srcAData);
  assign inBHit = tagHit(srcBValid, srcBData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ <= '0;
      aVQ  <= '0;
      bVQ  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        opQ[i]   <= '0;
        destQ[i] <= '0;
        aQ[i]    <= '0;
        bQ[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.clear) begin
          occQ[i] <= 1'b0;
        end else if (strobe.write && strobe.writeIdx == IDX_MAX_W'(i)) begin
          occQ[i]  <= 1'b1;
          opQ[i]   <= dispOp;
          destQ[i] <= dispDest;
          aVQ[i]   <= srcAValid || inAHit;
          aQ[i]    <= inAHit ? bcastData : srcAData;
          bVQ[i]   <= srcBValid || inBHit;
          bQ[i]    <= inBHit ? bcastData : srcBData;
        end else begin
          if (occQ[i] && tagHit(aVQ[i], aQ[i])) begin
            aVQ[i] <= 1'b1;
            aQ[i]  <= bcastData;
          end
          if (occQ[i] && tagHit(bVQ[i], bQ[i])) begin
            bVQ[i] <= 1'b1;
            bQ[i]  <= bcastData;
          end
          if (strobe.pop && strobe.popIdx == IDX_MAX_W'(i)) occQ[i] <= 1'b0;
        end
      end
    end
  end

  assign headReady = occQ[headIdx] && aVQ[headIdx] && bVQ[headIdx];
  assign issueOp   = opQ[headIdx];
  assign issueDest = destQ[headIdx];
  assign issueOpA  = aQ[headIdx];
  assign issueOpB  = bQ[headIdx];

  // R8: a dispatch that meets a matching broadcast lands already valid.
  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && !strobe.clear && inAHit) |=>
      aVQ[$past(strobe.writeIdx)] && aQ[$past(strobe.writeIdx)] == $past(bcastData));

  for (genvar g = 0; g < DEPTH; g++) begin : gChk
    // R4: waiting fields of occupied slots capture a matching broadcast.
    assert_wake_a_R4: assert property (@(posedge clk) disable iff (!rstN)
      (occQ[g] && !aVQ[g] && bcastValid && aQ[g][TAG_W-1:0] == bcastTag &&
       !strobe.clear && !(strobe.write && strobe.writeIdx == IDX_MAX_W'(g)))
      |=> aVQ[g] && aQ[g] == $past(bcastData));
    assert_wake_b_R4: assert property (@(posedge clk) disable iff (!rstN)
      (occQ[g] && !bVQ[g] && bcastValid && bQ[g][TAG_W-1:0] == bcastTag &&
       !strobe.clear && !(strobe.write && strobe.writeIdx == IDX_MAX_W'(g)))
      |=> bVQ[g] && bQ[g] == $past(bcastData));
    // R5: a valid operand is never overwritten by a broadcast.
    assert_hold_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
      (occQ[g] && aVQ[g] && bVQ[g] && !(strobe.write && strobe.writeIdx == IDX_MAX_W'(g)))
      |=> $stable(aQ[g]) && $stable(bQ[g]));
  end

endmodule

// File: rtl/rs_shelf.sv
module rs_shelf
  import rs_shelf_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              dispValid,
  output logic              dispReady,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [TAG_W-1:0]  dispDest,
  input  logic              srcAValid,
  input  logic [DATA_W-1:0] srcAData,
  input  logic              srcBValid,
  input  logic [DATA_W-1:0] srcBData,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  input  logic              euFree,
  output logic              issueValid,
  output logic [OP_W-1:0]   issueOp,
  output logic [TAG_W-1:0]  issueDest,
  output logic [DATA_W-1:0] issueOpA,
  output logic [DATA_W-1:0] issueOpB
);

  localparam int unsigned PTR_W = $clog2(DEPTH);

  rsStrobe_t        strobe;
  logic             headReady;
  logic [PTR_W-1:0] headIdx;

  rs_shelf_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .dispValid(dispValid),
    .euFree(euFree), .headReady(headReady), .dispReady(dispReady),
    .issueValid(issueValid), .headIdx(headIdx), .strobe(strobe)
  );

  rs_shelf_data #(.DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dispOp(dispOp), .dispDest(dispDest),
    .srcAValid(srcAValid), .srcAData(srcAData), .srcBValid(srcBValid), .srcBData(srcBData),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
    .headIdx(headIdx), .headReady(headReady), .issueOp(issueOp), .issueDest(issueDest),
    .issueOpA(issueOpA), .issueOpB(issueOpB)
  );

  // R7: nothing leaves unless the execution unit is free and no flush is on.
  assert_issue_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> euFree && !flush);

endmodule

// File: tb/rs_shelf_test.sv
`timescale 1ns/1ps
module rs_shelf_test;

  localparam int OP_W = 4, TAG_W = 4, DATA_W = 16, DEPTH = 4;

  logic              clk = 1'b0, rstN = 1'b0, flush = 1'b0;
  logic              dispValid = 1'b0, dispReady;
  logic [OP_W-1:0]   dispOp = '0;
  logic [TAG_W-1:0]  dispDest = '0;
  logic              srcAValid = 1'b0, srcBValid = 1'b0;
  logic [DATA_W-1:0] srcAData = '0, srcBData = '0;
  logic              bcastValid = 1'b0;
  logic [TAG_W-1:0]  bcastTag = '0;
  logic [DATA_W-1:0] bcastData = '0;
  logic              euFree = 1'b0, issueValid;
  logic [OP_W-1:0]   issueOp;
  logic [TAG_W-1:0]  issueDest;
  logic [DATA_W-1:0] issueOpA, issueOpB;

  always #2.5 clk = ~clk;

  rs_shelf #(.DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) uut (.*);

  typedef struct { logic [OP_W-1:0] op; logic [TAG_W-1:0] dest;
                   logic [DATA_W-1:0] a; logic [DATA_W-1:0] b; string req; } expItem_t;
  expItem_t expQ[$];
  int errors = 0, checks = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectIssue(input int op, input int dest, input int a, input int b, input string req);
    expItem_t e;
    e.op = OP_W'(op); e.dest = TAG_W'(dest); e.a = DATA_W'(a); e.b = DATA_W'(b); e.req = req;
    expQ.push_back(e);
  endtask

  // Monitor: compare every issued slot with the scoreboard head.
  always @(negedge clk) begin
    if (rstN && issueValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9/R10 unexpected issue", int'(issueOp), 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(issueOp == e.op && issueDest == e.dest && issueOpA == e.a && issueOpB == e.b,
              e.req, int'({issueOp, issueDest, issueOpA, issueOpB}),
              int'({e.op, e.dest, e.a, e.b}));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic dispatch(input int op, input int dest, input logic av, input int a,
                          input logic bv, input int b);
    dispValid = 1'b1; dispOp = OP_W'(op); dispDest = TAG_W'(dest);
    srcAValid = av; srcAData = DATA_W'(a); srcBValid = bv; srcBData = DATA_W'(b);
    step(1);
    dispValid = 1'b0;
  endtask

  task automatic broadcast(input int tag, input int data);
    bcastValid = 1'b1; bcastTag = TAG_W'(tag); bcastData = DATA_W'(data);
    step(1);
    bcastValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    // R1: empty after reset
    check(dispReady == 1'b1 && issueValid == 1'b0, "R1 reset state",
          int'({dispReady, issueValid}), 2);

    // R2/R3: fully valid slot issues unchanged
    euFree = 1'b1;
    expectIssue(1, 2, 16'h0100, 16'h0200, "R2 plain issue");
    dispatch(1, 2, 1, 16'h0100, 1, 16'h0200);
    step(2);

    // R7: busy execution unit blocks issue
    euFree = 1'b0;
    expectIssue(3, 4, 16'h0033, 16'h0044, "R7 issue after unit frees");
    dispatch(3, 4, 1, 16'h0033, 1, 16'h0044);
    step(3);
    check(issueValid == 1'b0, "R7 held while unit busy", int'(issueValid), 0);
    euFree = 1'b1;
    step(2);

    // R4/R5: one broadcast wakes two slots; valid field and other tags untouched
    euFree = 1'b0;
    expectIssue(5, 6, 16'hAAAA, 16'h0007, "R5 valid field kept");
    expectIssue(7, 8, 16'hAAAA, 16'hBBBB, "R4 second slot woken");
    dispatch(5, 6, 0, 5, 1, 16'h0007);
    dispatch(7, 8, 0, 5, 0, 6);
    euFree = 1'b1;
    step(1);
    check(issueValid == 1'b0, "R4 head waits for operand", int'(issueValid), 0);
    broadcast(7, 16'hDEAD);
    check(issueValid == 1'b0, "R5 foreign tag ignored", int'(issueValid), 0);
    broadcast(5, 16'hAAAA);
    step(1);
    check(issueValid == 1'b0, "R4 younger slot still waiting on B", int'(issueValid), 0);
    broadcast(6, 16'hBBBB);
    step(2);

    // R6: younger ready slot waits behind blocked head
    expectIssue(9, 1, 16'h0999, 16'h0001, "R6 head first");
    expectIssue(10, 3, 16'h0D0D, 16'h0E0E, "R6 younger second");
    dispatch(9, 1, 0, 9, 1, 16'h0001);
    dispatch(10, 3, 1, 16'h0D0D, 1, 16'h0E0E);
    step(2);
    check(issueValid == 1'b0, "R6 no bypass of head", int'(issueValid), 0);
    broadcast(9, 16'h0999);
    step(3);

    // R8: broadcast in the dispatch cycle
    expectIssue(11, 5, 16'h1234, 16'h5678, "R8 same-cycle capture");
    bcastValid = 1'b1; bcastTag = 4'd3; bcastData = 16'h1234;
    dispatch(11, 5, 0, 3, 1, 16'h5678);
    bcastValid = 1'b0;
    step(2);

    // R9: full buffer refuses dispatch
    euFree = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      expectIssue(k + 1, k, 16'h0F00 + k, 16'h0A00 + k, "R9 drained in order");
      dispatch(k + 1, k, 1, 16'h0F00 + k, 1, 16'h0A00 + k);
    end
    check(dispReady == 1'b0, "R9 full deasserts ready", int'(dispReady), 0);
    dispatch(15, 15, 1, 16'hFFFF, 1, 16'hFFFF);
    euFree = 1'b1;
    step(DEPTH + 3);
    check(issueValid == 1'b0 && expQ.size() == 0, "R9 rejected dispatch never issues",
          expQ.size(), 0);

    // R10: flush drops everything, including a same-cycle dispatch
    euFree = 1'b0;
    dispatch(2, 2, 1, 16'h2222, 1, 16'h2222);
    dispatch(4, 4, 1, 16'h4444, 1, 16'h4444);
    flush = 1'b1;
    dispatch(6, 6, 1, 16'h6666, 1, 16'h6666);
    flush = 1'b0;
    check(dispReady == 1'b1, "R10 ready after flush", int'(dispReady), 1);
    euFree = 1'b1;
    step(3);
    check(issueValid == 1'b0, "R10 nothing left to issue", int'(issueValid), 0);
    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule